// File: doc/BRIEF.md
# Language-Card Bank-Switch Controller

This block sits on the address bus of an 8-bit CPU and decides what serves the top 12 KB of the address space ($D000 to $FFFF). That window can come from ROM, from main RAM, or, for its lowest 4 KB only, from a second 4 KB RAM bank. Software changes the mapping by touching a small group of I/O addresses. The block watches every bus cycle, holds four mode flags (RAM read, RAM write, bank 2 select and alternate zero page), and in the same cycle drives chip selects and translated addresses for the ROM and the RAM.

Reads of $C080 to $C08F change the read source and the bank. The address bits [3] and [1:0] decide the new mode, and bit [2] is ignored. The write flag can only be armed by two back-to-back reads of the same odd switch address, so a stray single read cannot unlock RAM writes. A bus write to $C008 or $C009 turns the alternate-zero-page flag on or off. Three status locations ($C011, $C012 and $C016) return a flag in bit 7.

Flags change on the clock edge that ends the cycle which touched a switch. Decoding of the region uses the flags as they were at the start of each cycle.

Top module: `lc_bank_ctrl`

## Requirements
- R1: After reset the block reads the region from ROM, RAM writes are off, bank 1 is selected and the alternate-zero-page flag is clear (altzp_o = 0, every status location reads $00).
- R2: A read of a switch address with bits [1:0] = 00 makes the region read from RAM and clears the write flag. Bit [3] = 0 selects bank 2 and bit [3] = 1 selects bank 1.
- R3: A read of a switch address with bits [1:0] = 10 makes the region read from ROM and clears the write flag. The bank follows bit [3] as in R2.
- R4: A read of a switch address with bit [0] = 1 sets the read source (bits [1:0] = 01 gives ROM, 11 gives RAM) and the bank (as in R2). It sets the write flag only if the previous bus cycle was a read of the same address. Otherwise the write flag keeps its value.
- R5: A bus write to a switch address changes no flag. It also breaks a consecutive-read pair, because the last cycle is then no longer a read.
- R6: All sixteen addresses $C080 to $C08F act as switches, and address bit [2] has no effect on the result.
- R7: A read inside $D000 to $FFFF asserts ram_cs_o when RAM reads are on and rom_cs_o otherwise, with rom_addr_o = address − $D000. Outside that window neither chip select is asserted.
- R8: With bank 2 selected, RAM accesses to $D000 to $DFFF use ram_addr_o = $10000 + address[11:0]. All other RAM accesses use ram_addr_o = address.
- R9: A write inside $D000 to $FFFF asserts ram_cs_o and ram_we_o only while the write flag is set. Otherwise it asserts no chip select, so the ROM is never written.
- R10: A read of $C011, $C012 or $C016 asserts status_hit_o and returns $80 or $00 on rd_data_o for bank 2, RAM read and alternate zero page, in that order. Other addresses return status_hit_o = 0 and data $00.
- R11: A bus write to $C008 sets the alternate-zero-page flag and a bus write to $C009 clears it. The flag is shown on altzp_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | A bus cycle is in progress |
| addr_i | input | 16 | CPU address |
| we_i | input | 1 | 1 = write cycle, 0 = read cycle |
| rom_cs_o | output | 1 | ROM select for the upper region |
| rom_addr_o | output | 14 | Offset into the 12 KB ROM |
| ram_cs_o | output | 1 | RAM select for the upper region |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | 17 | Translated RAM address, bit 16 = alternate bank |
| rd_data_o | output | 8 | Status byte |
| status_hit_o | output | 1 | Address is a status location |
| altzp_o | output | 1 | Alternate-zero-page flag |

## Verification
The bench checks the write-arming pair in three settings: a single odd read, a true back-to-back pair, and a pair split by a write to the same switch. A design that armed on one read, or that ignored the direction of the last cycle, would then show ram_we_o on a later region write that must stay silent. It writes into the region while writes are off and expects no chip select at all, which catches a design that passes the write on to the ROM. It also checks the mirrored switch addresses, where a decoder that uses bit [2] would pick the wrong mode. Last, it checks the alternate-bank address for $Dxxx against $Exxx, where a faulty translator would send the upper pages to the 4 KB bank or leave the $Dxxx page in main RAM.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef struct packed {
    logic ram_rd;
    logic wr_en;
    logic bank2;
    logic altzp;
  } lc_flags_t;

  typedef struct packed {
    logic sw;      // mode switch read
    logic ram_rd;
    logic bank2;
    logic clr_wr;
    logic arm_wr;
    logic set_az;
    logic clr_az;
  } lc_cmd_t;
endpackage

// File: rtl/lc_switch_decode.sv
module lc_switch_decode
  import lc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SW_BASE = 'hC080,
  parameter logic [ADDR_W-1:0] AZ_ON   = 'hC008,
  parameter logic [ADDR_W-1:0] AZ_OFF  = 'hC009
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              consec_i,
  output lc_cmd_t           cmd_o
);
  logic sw_grp;
  logic unused_addr2;

  assign unused_addr2 = addr_i[2];
  assign sw_grp = addr_i[ADDR_W-1:4] == SW_BASE[ADDR_W-1:4];

  always_comb begin
    cmd_o        = '0;
    cmd_o.sw     = valid_i && !we_i && sw_grp;
    cmd_o.ram_rd = addr_i[0] == addr_i[1];   // 00 and 11 read RAM
    cmd_o.bank2  = !addr_i[3];
    cmd_o.clr_wr = !addr_i[0];
    cmd_o.arm_wr = addr_i[0] && consec_i;
    cmd_o.set_az = valid_i && we_i && (addr_i == AZ_ON);
    cmd_o.clr_az = valid_i && we_i && (addr_i == AZ_OFF);
  end
endmodule

// File: rtl/lc_mode_regs.sv
module lc_mode_regs
  import lc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  lc_cmd_t           cmd_i,
  output lc_flags_t         flags_o,
  output logic              consec_o
);
  lc_flags_t         flags_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic              last_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q     <= '0;
      last_addr_q <= '0;
      last_rd_q   <= 1'b0;
    end else begin
      if (valid_i) begin
        last_addr_q <= addr_i;
        last_rd_q   <= !we_i;
      end
      if (cmd_i.sw) begin
        flags_q.ram_rd <= cmd_i.ram_rd;
        flags_q.bank2  <= cmd_i.bank2;
        if (cmd_i.clr_wr)      flags_q.wr_en <= 1'b0;
        else if (cmd_i.arm_wr) flags_q.wr_en <= 1'b1;
      end
      if (cmd_i.set_az)      flags_q.altzp <= 1'b1;
      else if (cmd_i.clr_az) flags_q.altzp <= 1'b0;
    end
  end

  assign flags_o  = flags_q;
  assign consec_o = last_rd_q && (last_addr_q == addr_i);
endmodule

// File: rtl/lc_region_map.sv
module lc_region_map #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REGION_LO = 'hD000,
  parameter logic [ADDR_W-1:0] ALT_HI    = 'hE000,
  localparam int unsigned ROM_AW = $clog2((2**ADDR_W) - int'(REGION_LO)),
  localparam int unsigned ALT_AW = $clog2(int'(ALT_HI) - int'(REGION_LO)),
  localparam int unsigned RAM_AW = ADDR_W + 1
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              ram_rd_i,
  input  logic              wr_en_i,
  input  logic              bank2_i,
  output logic              rom_cs_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              ram_cs_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o
);
  logic              in_reg;
  logic              alt_pg;
  logic [ADDR_W-1:0] off;

  assign in_reg = valid_i && (addr_i >= REGION_LO);
  assign alt_pg = bank2_i && (addr_i < ALT_HI);
  assign off    = addr_i - REGION_LO;

  always_comb begin
    rom_cs_o = 1'b0;
    ram_cs_o = 1'b0;
    ram_we_o = 1'b0;
    if (in_reg) begin
      if (we_i) begin
        ram_cs_o = wr_en_i;
        ram_we_o = wr_en_i;
      end else begin
        ram_cs_o = ram_rd_i;
        rom_cs_o = !ram_rd_i;
      end
    end
  end

  assign rom_addr_o = off[ROM_AW-1:0];
  assign ram_addr_o = alt_pg ? {1'b1, {(ADDR_W-ALT_AW){1'b0}}, addr_i[ALT_AW-1:0]}
                             : {1'b0, addr_i};
endmodule

// File: rtl/lc_status_mux.sv
module lc_status_mux #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ST_BANK  = 'hC011,
  parameter logic [ADDR_W-1:0] ST_RAMRD = 'hC012,
  parameter logic [ADDR_W-1:0] ST_AZ    = 'hC016
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              bank2_i,
  input  logic              ram_rd_i,
  input  logic              altzp_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  logic rd, bit_v;

  assign rd = valid_i && !we_i;

  always_comb begin
    hit_o = 1'b0;
    bit_v = 1'b0;
    if (rd) begin
      unique case (addr_i)
        ST_BANK:  begin hit_o = 1'b1; bit_v = bank2_i;  end
        ST_RAMRD: begin hit_o = 1'b1; bit_v = ram_rd_i; end
        ST_AZ:    begin hit_o = 1'b1; bit_v = altzp_i;  end
        default:  ;
      endcase
    end
  end

  assign data_o = {bit_v, {(DATA_W-1){1'b0}}};
endmodule

// File: rtl/lc_bank_ctrl.sv
module lc_bank_ctrl
  import lc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] SW_BASE   = 'hC080,
  parameter logic [ADDR_W-1:0] AZ_ON     = 'hC008,
  parameter logic [ADDR_W-1:0] AZ_OFF    = 'hC009,
  parameter logic [ADDR_W-1:0] ST_BANK   = 'hC011,
  parameter logic [ADDR_W-1:0] ST_RAMRD  = 'hC012,
  parameter logic [ADDR_W-1:0] ST_AZ     = 'hC016,
  parameter logic [ADDR_W-1:0] REGION_LO = 'hD000,
  parameter logic [ADDR_W-1:0] ALT_HI    = 'hE000,
  localparam int unsigned ROM_AW = $clog2((2**ADDR_W) - int'(REGION_LO)),
  localparam int unsigned RAM_AW = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              rom_cs_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              ram_cs_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              status_hit_o,
  output logic              altzp_o
);
  lc_cmd_t   cmd;
  lc_flags_t flags;
  logic      consec;

  lc_switch_decode #(
    .ADDR_W(ADDR_W), .SW_BASE(SW_BASE), .AZ_ON(AZ_ON), .AZ_OFF(AZ_OFF)
  ) u_dec (
    .valid_i(bus_valid_i), .addr_i(addr_i), .we_i(we_i),
    .consec_i(consec), .cmd_o(cmd)
  );

  lc_mode_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(bus_valid_i), .addr_i(addr_i),
    .we_i(we_i), .cmd_i(cmd), .flags_o(flags), .consec_o(consec)
  );

  lc_region_map #(
    .ADDR_W(ADDR_W), .REGION_LO(REGION_LO), .ALT_HI(ALT_HI)
  ) u_map (
    .valid_i(bus_valid_i), .addr_i(addr_i), .we_i(we_i),
    .ram_rd_i(flags.ram_rd), .wr_en_i(flags.wr_en), .bank2_i(flags.bank2),
    .rom_cs_o(rom_cs_o), .rom_addr_o(rom_addr_o), .ram_cs_o(ram_cs_o),
    .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o)
  );

  lc_status_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ST_BANK(ST_BANK), .ST_RAMRD(ST_RAMRD), .ST_AZ(ST_AZ)
  ) u_st (
    .valid_i(bus_valid_i), .addr_i(addr_i), .we_i(we_i),
    .bank2_i(flags.bank2), .ram_rd_i(flags.ram_rd), .altzp_i(flags.altzp),
    .hit_o(status_hit_o), .data_o(rd_data_o)
  );

  assign altzp_o = flags.altzp;
endmodule

// File: rtl/lc_bank_ctrl_chk.sv
module lc_bank_ctrl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] SW_BASE  = 'hC080,
  parameter logic [ADDR_W-1:0] AZ_ON    = 'hC008,
  parameter logic [ADDR_W-1:0] ST_RAMRD = 'hC012
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              ram_rd_i,
  input logic              wr_en_i,
  input logic              bank2_i,
  input logic              rom_cs_i,
  input logic              ram_cs_i,
  input logic              ram_we_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              hit_i,
  input logic              altzp_i
);
  logic [ADDR_W-1:0] prev_addr;
  logic              prev_rd;
  logic              sw_any, sw_rd, pair;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_addr <= '0;
      prev_rd   <= 1'b0;
    end else if (valid_i) begin
      prev_addr <= addr_i;
      prev_rd   <= !we_i;
    end
  end

  assign sw_any = valid_i && (addr_i[ADDR_W-1:4] == SW_BASE[ADDR_W-1:4]);
  assign sw_rd  = sw_any && !we_i;
  assign pair   = prev_rd && (prev_addr == addr_i);

  a_r2_even_clears_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rd && !addr_i[0]) |=> !wr_en_i);

  a_r4_single_no_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rd && addr_i[0] && !pair && !wr_en_i) |=> !wr_en_i);

  a_r4_pair_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rd && addr_i[0] && pair) |=> wr_en_i);

  a_r5_write_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_any && we_i) |=> $stable({ram_rd_i, bank2_i, wr_en_i}));

  a_r9_rom_never_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && we_i && !wr_en_i) |-> (!rom_cs_i && !ram_we_i));

  a_r7_cs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_cs_i, ram_cs_i}));

  a_r10_status_ramrd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !we_i && addr_i == ST_RAMRD) |->
      (hit_i && rd_data_i == {ram_rd_i, {(DATA_W-1){1'b0}}}));

  a_r11_az_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && we_i && addr_i == AZ_ON) |=> altzp_i);
endmodule

bind lc_bank_ctrl lc_bank_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SW_BASE(SW_BASE),
  .AZ_ON(AZ_ON), .ST_RAMRD(ST_RAMRD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(bus_valid_i), .addr_i(addr_i),
  .we_i(we_i), .ram_rd_i(flags.ram_rd), .wr_en_i(flags.wr_en),
  .bank2_i(flags.bank2), .rom_cs_i(rom_cs_o), .ram_cs_i(ram_cs_o),
  .ram_we_i(ram_we_o), .rd_data_i(rd_data_o), .hit_i(status_hit_o),
  .altzp_i(altzp_o)
);

// File: tb/lc_bank_ctrl_tb.sv
`timescale 1ns/1ps
module lc_bank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] addr = '0;
  logic        we = 1'b0;
  logic        rom_cs, ram_cs, ram_we, st_hit, altzp;
  logic [13:0] rom_addr;
  logic [16:0] ram_addr;
  logic [7:0]  rd_data;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lc_bank_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .addr_i(addr), .we_i(we),
    .rom_cs_o(rom_cs), .rom_addr_o(rom_addr), .ram_cs_o(ram_cs), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .rd_data_o(rd_data), .status_hit_o(st_hit), .altzp_o(altzp)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one bus cycle; outputs settle 1 ns after the falling edge
  task automatic cyc(logic [15:0] a, logic w);
    @(negedge clk);
    valid = 1'b1; addr = a; we = w;
    #1;
  endtask

  task automatic status(logic [15:0] a, logic [7:0] exp, string tag);
    cyc(a, 1'b0);
    chk(tag, rd_data, exp);
    chk(tag, st_hit, 1);
  endtask

  task automatic t_reset;
    status(16'hC011, 8'h00, "R1 bank");
    status(16'hC012, 8'h00, "R1 ramrd");
    status(16'hC016, 8'h00, "R1 altzp");
    chk("R1 altzp_o", altzp, 0);
    cyc(16'hD000, 0);
    chk("R1 rom_cs", rom_cs, 1); chk("R1 ram_cs", ram_cs, 0); chk("R7 rom_addr", rom_addr, 0);
    cyc(16'hD000, 1);
    chk("R9 we", ram_we, 0); chk("R9 rom_cs", rom_cs, 0); chk("R9 ram_cs", ram_cs, 0);
  endtask

  task automatic t_ram_bank2;
    cyc(16'hC080, 0);
    status(16'hC011, 8'h80, "R2 bank2");
    status(16'hC012, 8'h80, "R2 ramrd");
    cyc(16'hD123, 0);
    chk("R2 ram_cs", ram_cs, 1); chk("R2 rom_cs", rom_cs, 0);
    chk("R8 alt addr", ram_addr, 17'h10123);
    cyc(16'hE456, 0);
    chk("R8 main addr", ram_addr, 17'h0E456);
    cyc(16'hD000, 1);
    chk("R2 no we", ram_we, 0);
  endtask

  task automatic t_rom_bank1;
    cyc(16'hC08A, 0);
    status(16'hC011, 8'h00, "R3 bank1");
    status(16'hC012, 8'h00, "R3 rom");
    cyc(16'hFFFC, 0);
    chk("R3 rom_cs", rom_cs, 1); chk("R7 rom_addr top", rom_addr, 14'h2FFC);
    cyc(16'h1234, 0);
    chk("R7 outside rom", rom_cs, 0); chk("R7 outside ram", ram_cs, 0);
    chk("R10 no hit", st_hit, 0); chk("R10 no data", rd_data, 0);
  endtask

  task automatic t_write_pair;
    cyc(16'hC089, 0);
    cyc(16'hD010, 1);
    chk("R4 single no we", ram_we, 0);
    cyc(16'hC089, 0);
    cyc(16'hC089, 0);
    cyc(16'hD010, 1);
    chk("R4 pair we", ram_we, 1); chk("R4 pair cs", ram_cs, 1);
    chk("R8 bank1 addr", ram_addr, 17'h0D010);
    status(16'hC012, 8'h00, "R4 rom read");
    cyc(16'hD010, 0);
    chk("R4 rom_cs", rom_cs, 1);
    cyc(16'hC08B, 0);            // single read, write flag already on
    cyc(16'hE000, 1);
    chk("R4 we kept", ram_we, 1);
    status(16'hC012, 8'h80, "R4 ram read");
  endtask

  task automatic t_write_break;
    cyc(16'hC08A, 0);
    cyc(16'hC08B, 0);
    cyc(16'hC08B, 1);
    cyc(16'hC08B, 0);
    cyc(16'hE000, 1);
    chk("R5 broken pair", ram_we, 0);
    cyc(16'hC082, 1);
    status(16'hC011, 8'h00, "R5 bank held");
    status(16'hC012, 8'h80, "R5 ramrd held");
  endtask

  task automatic t_mirror;
    cyc(16'hC084, 0);
    status(16'hC011, 8'h80, "R6 C084 bank");
    status(16'hC012, 8'h80, "R6 C084 ram");
    cyc(16'hC08E, 0);
    status(16'hC011, 8'h00, "R6 C08E bank");
    status(16'hC012, 8'h00, "R6 C08E rom");
    cyc(16'hC087, 0);
    cyc(16'hC087, 0);
    cyc(16'hD001, 1);
    chk("R6 C087 we", ram_we, 1);
    chk("R6 C087 addr", ram_addr, 17'h10001);
  endtask

  task automatic t_altzp;
    cyc(16'hC008, 1);
    status(16'hC016, 8'h80, "R11 on status");
    chk("R11 on pin", altzp, 1);
    cyc(16'hC009, 1);
    status(16'hC016, 8'h00, "R11 off status");
    chk("R11 off pin", altzp, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ram_bank2();
    t_rom_bank1();
    t_write_pair();
    t_write_break();
    t_mirror();
    t_altzp();
    @(negedge clk);
    valid = 1'b0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      summary();
      $finish;
    end
  end
endmodule